// File: doc/BRIEF.md
# Toroidal Tile Address Generator

This block walks a two-dimensional array as a sequence of tiles and sends out one tile element per handshake. The tile, the repetition space, the origin, the fitting matrix and the paving matrix are all fixed by parameters. A start pulse begins a sweep. The block then visits every repetition in turn, and every pattern element within each repetition. For each element it presents the two coordinates, a flat memory address and two end markers. The storage that the addresses point into sits outside this block.

Coordinates are computed with signed matrix products. They are then reduced to a non-negative remainder of the array size in each dimension. The array therefore behaves as a torus: an index that runs off one edge comes back in at the opposite edge, and a negative product lands in range as well. The number of tiles in a sweep is the product of the two repetition bounds.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, `out_valid` is low.
- R2: With no sweep active, a high `start` makes `out_valid` high at the next clock edge. The first element is presented at that edge. With no sweep active and `start` low, `out_valid` stays low.
- R3: The element for repetition (r0,r1) and pattern index (i0,i1) is built as follows. Take the sum ORG + PAV·r + FIT·i, with signed matrix entries, where dimension d gets ORGd + PAVd0·r0 + PAVd1·r1 + FITd0·i0 + FITd1·i1. `coord0` is that sum for dimension 0, reduced to its non-negative remainder modulo ARR0. `coord1` is the dimension-1 sum reduced the same way modulo ARR1.
- R4: Elements go out in this order: i0 fastest, then i1, then r0, then r1. Every pattern element of one repetition is sent before the next repetition begins.
- R5: `addr` equals coord1·ARR0 + coord0.
- R6: `tile_last` is high exactly on the element with i0 = PAT0−1 and i1 = PAT1−1.
- R7: `sweep_last` is high exactly on the final element of the sweep, and it implies `tile_last`. A sweep holds REP0·REP1·PAT0·PAT1 elements. After the final element is accepted, `out_valid` is low on the following cycle.
- R8: A `start` pulse that arrives while a sweep is active is ignored. The sweep goes on unchanged and does not restart once it ends.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and every output stay unchanged on the next cycle.
- R10: While `out_valid` is high, `coord0` < ARR0 and `coord1` < ARR1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sweep when idle |
| out_ready | input | 1 | Consumer accepts the current element |
| out_valid | output | 1 | An element is presented |
| coord0 | output | $clog2(ARR0+1) | Dimension-0 coordinate |
| coord1 | output | $clog2(ARR1+1) | Dimension-1 coordinate |
| addr | output | $clog2(ARR0*ARR1+1) | Flat address coord1·ARR0 + coord0 |
| tile_last | output | 1 | Final element of a tile |
| sweep_last | output | 1 | Final element of the sweep |

## Verification
The checker assumes that `rst_n` is applied before the first sweep. It also assumes the parameters give positive array, pattern and repetition sizes, so the remainder is always defined. All other inputs may take any value, since `start` and `out_ready` are legal in every cycle. The stimulus stays within these bounds: reset is held for several cycles, and every instance uses positive sizes. The stimulus varies `out_ready` with stalls in several phases and pulses `start` in the middle of a sweep. It also includes an instance whose matrices carry negative entries, so that the non-negative wrap is exercised as well as the positive overflow.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int ARR0 = 6,
  parameter int ARR1 = 6,
  parameter int PAT0 = 2,
  parameter int PAT1 = 3,
  parameter int REP0 = 3,
  parameter int REP1 = 2,
  parameter int ORG0 = 5,
  parameter int ORG1 = 4,
  parameter int FIT00 = 1,
  parameter int FIT01 = 0,
  parameter int FIT10 = 0,
  parameter int FIT11 = 1,
  parameter int PAV00 = 2,
  parameter int PAV01 = 0,
  parameter int PAV10 = 0,
  parameter int PAV11 = 3,
  localparam int C0W = $clog2(ARR0 + 1),
  localparam int C1W = $clog2(ARR1 + 1),
  localparam int AW  = $clog2(ARR0 * ARR1 + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [C0W-1:0] coord0,
  output logic [C1W-1:0] coord1,
  output logic [AW-1:0]  addr,
  output logic           tile_last,
  output logic           sweep_last
);
  localparam int IW0 = $clog2(PAT0 + 1);
  localparam int IW1 = $clog2(PAT1 + 1);
  localparam int RW0 = $clog2(REP0 + 1);
  localparam int RW1 = $clog2(REP1 + 1);

  logic           busy;
  logic [IW0-1:0] i0;
  logic [IW1-1:0] i1;
  logic [RW0-1:0] r0;
  logic [RW1-1:0] r1;
  logic           i0_end, i1_end, r0_end, r1_end;
  int             s0, s1, m0, m1;

  assign i0_end = (int'(i0) == PAT0 - 1);
  assign i1_end = (int'(i1) == PAT1 - 1);
  assign r0_end = (int'(r0) == REP0 - 1);
  assign r1_end = (int'(r1) == REP1 - 1);

  assign out_valid  = busy;
  assign tile_last  = busy & i0_end & i1_end;
  assign sweep_last = tile_last & r0_end & r1_end;

  always_comb begin
    s0 = ORG0 + PAV00 * int'(r0) + PAV01 * int'(r1) + FIT00 * int'(i0) + FIT01 * int'(i1);
    s1 = ORG1 + PAV10 * int'(r0) + PAV11 * int'(r1) + FIT10 * int'(i0) + FIT11 * int'(i1);
    m0 = s0 % ARR0;
    m1 = s1 % ARR1;
    if (m0 < 0) m0 = m0 + ARR0;
    if (m1 < 0) m1 = m1 + ARR1;
  end

  assign coord0 = C0W'(m0);
  assign coord1 = C1W'(m1);
  assign addr   = AW'(m1 * ARR0 + m0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      i0 <= '0;
      i1 <= '0;
      r0 <= '0;
      r1 <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        i0 <= '0;
        i1 <= '0;
        r0 <= '0;
        r1 <= '0;
      end
    end else if (out_ready) begin
      i0 <= i0_end ? '0 : i0 + 1'b1;
      if (i0_end) begin
        i1 <= i1_end ? '0 : i1 + 1'b1;
        if (i1_end) begin
          r0 <= r0_end ? '0 : r0 + 1'b1;
          if (r0_end) begin
            r1 <= r1_end ? '0 : r1 + 1'b1;
            if (r1_end) busy <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int ARR0 = 6,
  parameter int ARR1 = 6,
  parameter int C0W = 3,
  parameter int C1W = 3,
  parameter int AW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           out_ready,
  input logic           out_valid,
  input logic [C0W-1:0] coord0,
  input logic [C1W-1:0] coord1,
  input logic [AW-1:0]  addr,
  input logic           tile_last,
  input logic           sweep_last
);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !start) |=> !out_valid);

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start) |=> out_valid);

  assert_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(addr) == int'(coord1) * ARR0 + int'(coord0)));

  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_last |-> tile_last);

  assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && sweep_last) |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(coord0) && $stable(coord1)
      && $stable(addr) && $stable(tile_last) && $stable(sweep_last)));

  assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(coord0) < ARR0 && int'(coord1) < ARR1));
endmodule

bind tile_addr_gen tile_addr_gen_chk #(
  .ARR0(ARR0), .ARR1(ARR1), .C0W(C0W), .C1W(C1W), .AW(AW)
) u_chk (.*);

// File: tb/tb_tile_addr_gen.sv
module tb_tile_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int A0 = 6, A1 = 6, P0 = 2, P1 = 3, Q0 = 3, Q1 = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rdy = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  logic       v_a, tl_a, sl_a, v_b, tl_b, sl_b;
  logic [2:0] c0_a, c1_a, c0_b, c1_b;
  logic [5:0] ad_a, ad_b;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tile_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(rdy),
    .out_valid(v_a), .coord0(c0_a), .coord1(c1_a), .addr(ad_a),
    .tile_last(tl_a), .sweep_last(sl_a));

  tile_addr_gen #(
    .ORG0(1), .ORG1(0),
    .FIT00(1), .FIT01(-1), .FIT10(0), .FIT11(-2),
    .PAV00(-2), .PAV01(0), .PAV10(1), .PAV11(-3)
  ) dut_neg (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(rdy),
    .out_valid(v_b), .coord0(c0_b), .coord1(c1_b), .addr(ad_b),
    .tile_last(tl_b), .sweep_last(sl_b));

  function automatic int wrapm(int v, int m);
    int t = v % m;
    if (t < 0) t = t + m;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_elem(input int r0, input int r1, input int i0, input int i1);
    int e0a = wrapm(5 + 2 * r0 + i0, A0);
    int e1a = wrapm(4 + 3 * r1 + i1, A1);
    int e0b = wrapm(1 - 2 * r0 + i0 - i1, A0);
    int e1b = wrapm(r0 - 3 * r1 - 2 * i1, A1);
    int tl  = (i0 == P0 - 1 && i1 == P1 - 1) ? 1 : 0;
    int sl  = (tl == 1 && r0 == Q0 - 1 && r1 == Q1 - 1) ? 1 : 0;
    check(v_a && v_b, "R4 valid during sweep", int'(v_a), 1);
    check(int'(c0_a) == e0a && int'(c1_a) == e1a, "R3/R4 coords",
          int'(c1_a) * 10 + int'(c0_a), e1a * 10 + e0a);
    check(int'(c0_b) == e0b && int'(c1_b) == e1b, "R3 negative wrap coords",
          int'(c1_b) * 10 + int'(c0_b), e1b * 10 + e0b);
    check(int'(ad_a) == e1a * A0 + e0a && int'(ad_b) == e1b * A0 + e0b, "R5 addr",
          int'(ad_a), e1a * A0 + e0a);
    check(int'(tl_a) == tl && int'(tl_b) == tl, "R6 tile_last", int'(tl_a), tl);
    check(int'(sl_a) == sl && int'(sl_b) == sl, "R7 sweep_last", int'(sl_a), sl);
  endtask

  task automatic sweep(input int mode);
    int n = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(v_a && v_b, "R2 launch", int'(v_a), 1);
    for (int r1 = 0; r1 < Q1; r1++)
      for (int r0 = 0; r0 < Q0; r0++)
        for (int i1 = 0; i1 < P1; i1++)
          for (int i0 = 0; i0 < P0; i0++) begin
            check_elem(r0, r1, i0, i1);
            if (mode != 0 && (n % mode) == 1) begin
              rdy = 1'b0;
              start = (n == 7);
              @(negedge clk);
              start = 1'b0;
              check_elem(r0, r1, i0, i1);
              check(v_a, "R9 hold under stall", int'(v_a), 1);
            end
            rdy = 1'b1;
            start = (n == 4);
            @(negedge clk);
            start = 1'b0;
            n++;
          end
    check(!v_a && !v_b, "R7 idle after final element", int'(v_a), 0);
    check(n == Q0 * Q1 * P0 * P1, "R7 element count", n, Q0 * Q1 * P0 * P1);
    @(negedge clk);
    check(!v_a && !v_b, "R8 no restart from mid-sweep start", int'(v_a), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!v_a && !v_b, "R1 reset state", int'(v_a), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!v_a && !v_b, "R2 idle without start", int'(v_a), 0);
    rdy = 1'b1;
    sweep(0);
    sweep(3);
    sweep(2);
    rdy = 1'b0;
    @(negedge clk);
    check(!v_a, "R2 idle with ready low", int'(v_a), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule